// File: doc/BRIEF.md
# Word Load/Store Execution Sequencer

This block carries out one single-word memory transfer for a small 32-bit core. The core hands it a decoded request: the direction (load or store), the base register value and index, an offset (an immediate or the value of an offset register), whether the offset is applied before or after the access, whether it is added or subtracted, a write-back flag, and the index of the data register. It also supplies the store data and the address of the current instruction. The block forms the effective address, runs a fixed sequence of bus cycles, and marks each cycle as non-sequential, sequential or internal. It samples an abort line during the data cycle. At the end it reports the loaded word, the updated base value, and whether the transfer completed, aborted or was refused.

The request is taken when `reqValid` is high and `busy` is low. A completion pulse on `doneValid` carries the register updates for the register file to commit. Requests that use the program counter in ways the core cannot support are refused without any bus activity.

Top module: `ldst_sequencer`

## Requirements
- R1: With pre-indexing the bus address is base plus offset (`reqUp`=1) or base minus offset (`reqUp`=0). With post-indexing the bus address is the unmodified base. The modified address is reported on `wbData` with `wbIdx` equal to the base index. `wbWe` is set when `reqWb` is 1 or when the transfer is post-indexed (`reqPre`=0).
- R2: When the base index is 15 (program counter), the base value used is `reqPc` + 8 and `reqBase` is ignored.
- R3: A store drives the data register onto `memWdata` unrotated for any address alignment. When the data index is 15, the stored value is `reqPc` + 12 instead of `reqStoreData`.
- R4: A request is refused if any of these holds: base index 15 together with write-back or post-indexing; a register offset (`reqOffIsReg`=1) with offset index 15; or a post-indexed register offset whose index equals the base index. A refused request produces `doneValid` and `doneIllegal` one cycle after acceptance, with no bus cycle and with `rdWe`=0 and `wbWe`=0.
- R5: If `memAbort` is high in the data cycle (the first bus cycle), the sequence ends after that cycle. `doneAbort` is then set and both `rdWe` and `wbWe` are 0.
- R6: A load whose data index is not 15 runs the cycle types N, I, S, in that order.
- R7: A load into index 15 runs the cycle types N, I, N, S, S, in that order.
- R8: A store runs the cycle types N, N. `memWrite` is high only in the first of these cycles.
- R9: A load returns `memRdata` rotated right by 8 times the low two address bits, so that the addressed byte ends up in bits 7:0. `rdWe` is set and `rdIdx` equals the data index.
- R10: `busy` is high from the cycle after acceptance until `doneValid` appears, which is the cycle after the last bus cycle. Requests presented while `busy` is high are ignored.
- R11: `memCycle` encodes the cycle type as 00 = N, 01 = S, 10 = I and 11 = no bus cycle. After reset, `memCycle`=11 and `busy`, `doneValid` and `memWrite` are all 0.
- R12: For a load whose data index equals the base index, the loaded value is written and `wbWe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Request present |
| reqLoad | input | 1 | 1 = load, 0 = store |
| reqPre | input | 1 | 1 = offset applied before the access |
| reqUp | input | 1 | 1 = add offset, 0 = subtract |
| reqWb | input | 1 | Write-back requested |
| reqOffIsReg | input | 1 | Offset comes from a register |
| reqBaseIdx | input | 4 | Base register index |
| reqOffIdx | input | 4 | Offset register index |
| reqDataIdx | input | 4 | Destination or source register index |
| reqBase | input | 32 | Base register value |
| reqOffset | input | 32 | Offset value |
| reqStoreData | input | 32 | Source register value for stores |
| reqPc | input | 32 | Address of the current instruction |
| busy | output | 1 | Sequence in progress |
| memAddr | output | 32 | Bus address |
| memWdata | output | 32 | Bus write data |
| memWrite | output | 1 | Write strobe |
| memCycle | output | 2 | Cycle type |
| memRdata | input | 32 | Bus read data |
| memAbort | input | 1 | Data abort from the memory system |
| doneValid | output | 1 | Completion pulse |
| doneAbort | output | 1 | Transfer aborted |
| doneIllegal | output | 1 | Request refused |
| rdWe | output | 1 | Write the loaded value |
| rdIdx | output | 4 | Destination index |
| rdData | output | 32 | Loaded value |
| wbWe | output | 1 | Write the updated base |
| wbIdx | output | 4 | Base index for write-back |
| wbData | output | 32 | Updated base value |

## Verification
The assertions check several properties on every cycle. A write strobe appears only in an N cycle. An abort report always follows an N cycle in which the abort line was high, and it never comes with a register update. A refused request leaves the bus idle. No completion appears while the block is busy. Load and base updates never target the same register. The bench sweeps direction, indexing, add/subtract, write-back, address alignment and the register-index choices, including the program counter cases. It checks the exact cycle-type order, the address and the data values against arithmetic in the bench. It also checks that requests held during a busy sequence are ignored. These ordering and value checks depend on whole scenarios and only the bench can show them.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  typedef enum logic [1:0] {
    CYC_N    = 2'b00,
    CYC_S    = 2'b01,
    CYC_I    = 2'b10,
    CYC_NONE = 2'b11
  } cycType_e;

  typedef enum logic [1:0] {
    SEQ_LOAD   = 2'd0,
    SEQ_LOADPC = 2'd1,
    SEQ_STORE  = 2'd2
  } seqCls_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch a legal request
    logic dataCyc;   // current cycle is the data cycle
    logic finish;    // last cycle of the sequence
    logic abortEnd;  // sequence ends through an abort
    logic illegal;   // refused request accepted this cycle
  } ldstStrobe_t;

endpackage

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqLoad,
  input  logic             reqPre,
  input  logic             reqWb,
  input  logic             reqOffIsReg,
  input  logic [IDX_W-1:0] reqBaseIdx,
  input  logic [IDX_W-1:0] reqOffIdx,
  input  logic [IDX_W-1:0] reqDataIdx,
  input  logic             memAbort,
  output logic             busy,
  output cycType_e         memCycle,
  output ldstStrobe_t      strobe
);

  localparam int STEP_W = 3;
  localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);

  logic             running;
  seqCls_e          cls;
  logic [STEP_W-1:0] step;
  logic             accept, illegalReq, lastStep;

  function automatic logic [STEP_W-1:0] lenOf(input seqCls_e c);
    case (c)
      SEQ_LOAD:   lenOf = STEP_W'(3);
      SEQ_LOADPC: lenOf = STEP_W'(5);
      default:    lenOf = STEP_W'(2);
    endcase
  endfunction

  function automatic cycType_e cycAt(input seqCls_e c, input logic [STEP_W-1:0] s);
    cycAt = CYC_N;
    case (c)
      SEQ_LOAD:   cycAt = (s == 1) ? CYC_I : (s == 2) ? CYC_S : CYC_N;
      SEQ_LOADPC: cycAt = (s == 1) ? CYC_I : (s >= 3) ? CYC_S : CYC_N;
      default:    cycAt = CYC_N;
    endcase
  endfunction

  always_comb begin
    accept     = reqValid && !running;
    illegalReq = ((reqBaseIdx == PC_SEL) && (reqWb || !reqPre))
              || (reqOffIsReg && (reqOffIdx == PC_SEL))
              || (!reqPre && reqOffIsReg && (reqOffIdx == reqBaseIdx));
    lastStep   = running && (step == lenOf(cls) - STEP_W'(1));
    strobe.capture  = accept && !illegalReq;
    strobe.illegal  = accept && illegalReq;
    strobe.dataCyc  = running && (step == '0);
    strobe.abortEnd = strobe.dataCyc && memAbort;
    strobe.finish   = lastStep || strobe.abortEnd;
    memCycle = running ? cycAt(cls, step) : CYC_NONE;
    busy     = running;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      step    <= '0;
      cls     <= SEQ_LOAD;
    end else if (strobe.capture) begin
      running <= 1'b1;
      step    <= '0;
      cls     <= !reqLoad ? SEQ_STORE :
                 (reqDataIdx == PC_SEL) ? SEQ_LOADPC : SEQ_LOAD;
    end else if (running) begin
      if (strobe.finish) begin
        running <= 1'b0;
        step    <= '0;
      end else begin
        step <= step + STEP_W'(1);
      end
    end
  end

  // R5: after an abort no further bus cycle is issued
  a_r5_abort_stops_bus: assert property (@(posedge clk) disable iff (!rstN)
    strobe.abortEnd |=> (memCycle == CYC_NONE));

  // R6 R7 R8: every sequence opens with an N data cycle
  a_r6_data_cycle_n: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (memCycle == CYC_N));

endmodule

// File: rtl/ldst_dpath.sv
module ldst_dpath
  import ldst_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int IDX_W        = 4,
  parameter int PC_IDX       = 15,
  parameter int PC_BASE_ADJ  = 8,
  parameter int PC_STORE_ADJ = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ldstStrobe_t       strobe,
  input  logic              reqLoad,
  input  logic              reqPre,
  input  logic              reqUp,
  input  logic              reqWb,
  input  logic [IDX_W-1:0]  reqBaseIdx,
  input  logic [IDX_W-1:0]  reqDataIdx,
  input  logic [DATA_W-1:0] reqBase,
  input  logic [DATA_W-1:0] reqOffset,
  input  logic [DATA_W-1:0] reqStoreData,
  input  logic [DATA_W-1:0] reqPc,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWrite,
  output logic              doneValid,
  output logic              doneAbort,
  output logic              doneIllegal,
  output logic              rdWe,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic              wbWe,
  output logic [IDX_W-1:0]  wbIdx,
  output logic [DATA_W-1:0] wbData
);

  localparam int BSEL_W = $clog2(DATA_W / 8);
  localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);

  logic [DATA_W-1:0] baseEff, modAddr, storeEff;
  logic [DATA_W-1:0] addrQ, wbValQ, storeQ, rdBufQ;
  logic              isLoadQ, doWbQ;
  logic [IDX_W-1:0]  dataIdxQ, baseIdxQ;

  function automatic logic [DATA_W-1:0] rotR(input logic [DATA_W-1:0] w,
                                              input logic [BSEL_W-1:0] sel);
    logic [2*DATA_W-1:0] dbl;
    dbl  = {w, w} >> (int'(sel) * 8);
    rotR = dbl[DATA_W-1:0];
  endfunction

  always_comb begin
    baseEff  = (reqBaseIdx == PC_SEL) ? reqPc + DATA_W'(PC_BASE_ADJ) : reqBase;
    modAddr  = reqUp ? baseEff + reqOffset : baseEff - reqOffset;
    storeEff = (reqDataIdx == PC_SEL) ? reqPc + DATA_W'(PC_STORE_ADJ) : reqStoreData;
    memAddr  = addrQ;
    memWdata = storeQ;
    memWrite = strobe.dataCyc && !isLoadQ;
  end

  // request latch and read capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      wbValQ   <= '0;
      storeQ   <= '0;
      rdBufQ   <= '0;
      isLoadQ  <= 1'b0;
      doWbQ    <= 1'b0;
      dataIdxQ <= '0;
      baseIdxQ <= '0;
    end else begin
      if (strobe.capture) begin
        addrQ    <= reqPre ? modAddr : baseEff;
        wbValQ   <= modAddr;
        storeQ   <= storeEff;
        isLoadQ  <= reqLoad;
        doWbQ    <= reqWb || !reqPre;
        dataIdxQ <= reqDataIdx;
        baseIdxQ <= reqBaseIdx;
      end
      if (strobe.dataCyc && isLoadQ) begin
        rdBufQ <= rotR(memRdata, addrQ[BSEL_W-1:0]);
      end
    end
  end

  // completion report
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneValid   <= 1'b0;
      doneAbort   <= 1'b0;
      doneIllegal <= 1'b0;
      rdWe        <= 1'b0;
      wbWe        <= 1'b0;
      rdIdx       <= '0;
      rdData      <= '0;
      wbIdx       <= '0;
      wbData      <= '0;
    end else begin
      doneValid   <= strobe.finish || strobe.illegal;
      doneIllegal <= strobe.illegal;
      doneAbort   <= strobe.finish && strobe.abortEnd;
      rdWe        <= strobe.finish && !strobe.abortEnd && isLoadQ;
      wbWe        <= strobe.finish && !strobe.abortEnd && doWbQ
                     && !(isLoadQ && (dataIdxQ == baseIdxQ));
      if (strobe.finish) begin
        rdIdx  <= dataIdxQ;
        rdData <= rdBufQ;
        wbIdx  <= baseIdxQ;
        wbData <= wbValQ;
      end
    end
  end

  // R5: an aborted transfer commits nothing
  a_r5_abort_no_commit: assert property (@(posedge clk) disable iff (!rstN)
    doneAbort |-> (!rdWe && !wbWe));

  // R12: loaded value and base update never aim at the same register
  a_r12_no_dual_target: assert property (@(posedge clk) disable iff (!rstN)
    (rdWe && wbWe) |-> (rdIdx != wbIdx));

  // R4: a refused request carries no register update
  a_r4_illegal_no_commit: assert property (@(posedge clk) disable iff (!rstN)
    doneIllegal |-> (!rdWe && !wbWe && !doneAbort));

endmodule

// File: rtl/ldst_sequencer.sv
module ldst_sequencer
  import ldst_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int IDX_W        = 4,
  parameter int PC_IDX       = 15,
  parameter int PC_BASE_ADJ  = 8,
  parameter int PC_STORE_ADJ = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqLoad,
  input  logic              reqPre,
  input  logic              reqUp,
  input  logic              reqWb,
  input  logic              reqOffIsReg,
  input  logic [IDX_W-1:0]  reqBaseIdx,
  input  logic [IDX_W-1:0]  reqOffIdx,
  input  logic [IDX_W-1:0]  reqDataIdx,
  input  logic [DATA_W-1:0] reqBase,
  input  logic [DATA_W-1:0] reqOffset,
  input  logic [DATA_W-1:0] reqStoreData,
  input  logic [DATA_W-1:0] reqPc,
  output logic              busy,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWrite,
  output logic [1:0]        memCycle,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAbort,
  output logic              doneValid,
  output logic              doneAbort,
  output logic              doneIllegal,
  output logic              rdWe,
  output logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic              wbWe,
  output logic [IDX_W-1:0]  wbIdx,
  output logic [DATA_W-1:0] wbData
);

  ldstStrobe_t strobe;
  cycType_e    cycT;

  assign memCycle = cycT;

  ldst_ctrl #(.IDX_W(IDX_W), .PC_IDX(PC_IDX)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLoad(reqLoad),
    .reqPre(reqPre), .reqWb(reqWb), .reqOffIsReg(reqOffIsReg),
    .reqBaseIdx(reqBaseIdx), .reqOffIdx(reqOffIdx), .reqDataIdx(reqDataIdx),
    .memAbort(memAbort), .busy(busy), .memCycle(cycT), .strobe(strobe)
  );

  ldst_dpath #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .PC_IDX(PC_IDX),
    .PC_BASE_ADJ(PC_BASE_ADJ), .PC_STORE_ADJ(PC_STORE_ADJ)
  ) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqLoad(reqLoad),
    .reqPre(reqPre), .reqUp(reqUp), .reqWb(reqWb), .reqBaseIdx(reqBaseIdx),
    .reqDataIdx(reqDataIdx), .reqBase(reqBase), .reqOffset(reqOffset),
    .reqStoreData(reqStoreData), .reqPc(reqPc), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWrite(memWrite),
    .doneValid(doneValid), .doneAbort(doneAbort), .doneIllegal(doneIllegal),
    .rdWe(rdWe), .rdIdx(rdIdx), .rdData(rdData), .wbWe(wbWe),
    .wbIdx(wbIdx), .wbData(wbData)
  );

  // R8: a write strobe only ever appears in an N cycle
  a_r8_write_in_n: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> (memCycle == 2'b00));

  // R5: an abort report follows an N cycle that saw the abort line high
  a_r5_abort_source: assert property (@(posedge clk) disable iff (!rstN)
    doneAbort |-> ($past(memCycle) == 2'b00 && $past(memAbort)));

  // R4: a refused request leaves the bus idle
  a_r4_illegal_no_bus: assert property (@(posedge clk) disable iff (!rstN)
    doneIllegal |-> ($past(memCycle) == 2'b11));

  // R10: no completion while a sequence is still running
  a_r10_no_done_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !doneValid);

endmodule

// File: tb/test_ldst_sequencer.sv
`timescale 1ns/1ps
module test_ldst_sequencer;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqLoad, reqPre, reqUp, reqWb, reqOffIsReg;
  logic [3:0]  reqBaseIdx, reqOffIdx, reqDataIdx;
  logic [31:0] reqBase, reqOffset, reqStoreData, reqPc;
  logic        busy, memWrite, memAbort;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [1:0]  memCycle;
  logic        doneValid, doneAbort, doneIllegal, rdWe, wbWe;
  logic [3:0]  rdIdx, wbIdx;
  logic [31:0] rdData, wbData;

  int nVec = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A3C_96E1;
  endfunction

  assign memRdata = memWord(memAddr);

  ldst_sequencer i_ldst_sequencer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqLoad(reqLoad),
    .reqPre(reqPre), .reqUp(reqUp), .reqWb(reqWb), .reqOffIsReg(reqOffIsReg),
    .reqBaseIdx(reqBaseIdx), .reqOffIdx(reqOffIdx), .reqDataIdx(reqDataIdx),
    .reqBase(reqBase), .reqOffset(reqOffset), .reqStoreData(reqStoreData),
    .reqPc(reqPc), .busy(busy), .memAddr(memAddr), .memWdata(memWdata),
    .memWrite(memWrite), .memCycle(memCycle), .memRdata(memRdata),
    .memAbort(memAbort), .doneValid(doneValid), .doneAbort(doneAbort),
    .doneIllegal(doneIllegal), .rdWe(rdWe), .rdIdx(rdIdx), .rdData(rdData),
    .wbWe(wbWe), .wbIdx(wbIdx), .wbData(wbData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doXfer(input logic ld, input logic pre, input logic up, input logic wb,
                        input logic offReg, input logic abt, input logic hold,
                        input logic [3:0] bIdx, input logic [3:0] oIdx, input logic [3:0] dIdx,
                        input logic [31:0] base, input logic [31:0] off,
                        input logic [31:0] sdata, input logic [31:0] pc);
    logic [31:0] bEff, sum, addr, sval, w, rdExp;
    logic [63:0] dbl;
    logic        ill, expRdWe, expWbWe;
    logic [1:0]  expSeq[8];
    logic [1:0]  gotSeq[8];
    int          expN, gotN, wrCnt, guard;
    logic [31:0] gotAddr, gotWd;
    logic        gotWr;
    string       sTag;

    bEff = (bIdx == 4'd15) ? pc + 32'd8 : base;
    sum  = up ? bEff + off : bEff - off;
    addr = pre ? sum : bEff;
    sval = (dIdx == 4'd15) ? pc + 32'd12 : sdata;
    w    = memWord(addr);
    dbl  = {w, w} >> (addr[1:0] * 8);
    rdExp = dbl[31:0];
    ill = ((bIdx == 4'd15) && (wb || !pre)) || (offReg && oIdx == 4'd15)
       || (!pre && offReg && oIdx == bIdx);
    expRdWe = !ill && !abt && ld;
    expWbWe = !ill && !abt && (wb || !pre) && !(ld && dIdx == bIdx);
    for (int k = 0; k < 8; k++) expSeq[k] = 2'b11;
    if (ill) begin
      expN = 0; sTag = "R4";
    end else if (abt) begin
      expN = 1; expSeq[0] = 2'b00; sTag = "R5";
    end else if (!ld) begin
      expN = 2; expSeq[0] = 2'b00; expSeq[1] = 2'b00; sTag = "R8";
    end else if (dIdx == 4'd15) begin
      expN = 5; expSeq[0] = 2'b00; expSeq[1] = 2'b10; expSeq[2] = 2'b00;
      expSeq[3] = 2'b01; expSeq[4] = 2'b01; sTag = "R7";
    end else begin
      expN = 3; expSeq[0] = 2'b00; expSeq[1] = 2'b10; expSeq[2] = 2'b01; sTag = "R6";
    end

    @(negedge clk);
    reqLoad = ld; reqPre = pre; reqUp = up; reqWb = wb; reqOffIsReg = offReg;
    reqBaseIdx = bIdx; reqOffIdx = oIdx; reqDataIdx = dIdx;
    reqBase = base; reqOffset = off; reqStoreData = sdata; reqPc = pc;
    reqValid = 1'b1; memAbort = abt;
    gotN = 0; wrCnt = 0; guard = 0; gotAddr = '0; gotWd = '0; gotWr = 1'b0;
    for (int k = 0; k < 8; k++) gotSeq[k] = 2'b11;
    @(posedge clk);
    forever begin
      @(negedge clk);
      if (doneValid) break;
      if (memCycle != 2'b11) begin
        if (gotN < 8) gotSeq[gotN] = memCycle;
        if (gotN == 0) begin gotAddr = memAddr; gotWd = memWdata; gotWr = memWrite; end
        else if (memWrite) wrCnt++;
        gotN++;
      end
      if (hold && busy) begin
        // R10: an illegal request held during busy must not be taken
        reqWb = 1'b1; reqBaseIdx = 4'd15;
      end else begin
        reqValid = 1'b0;
      end
      guard++;
      if (guard > 20) break;
    end
    reqValid = 1'b0; memAbort = 1'b0;

    chk({sTag, " R10 done seen"}, {31'd0, doneValid}, 32'd1);
    chk({sTag, " R4 illegal flag"}, {31'd0, doneIllegal}, {31'd0, ill});
    chk({sTag, " R5 abort flag"}, {31'd0, doneAbort}, {31'd0, !ill && abt});
    chk({sTag, " R11 cycle count"}, gotN, expN);
    for (int k = 0; k < 5; k++)
      chk({sTag, " R11 cycle type order"}, {30'd0, gotSeq[k]}, {30'd0, expSeq[k]});
    chk({sTag, " R9 rdWe"}, {31'd0, rdWe}, {31'd0, expRdWe});
    chk({sTag, " R12 wbWe"}, {31'd0, wbWe}, {31'd0, expWbWe});
    if (!ill) begin
      chk((bIdx == 4'd15) ? "R2 address" : "R1 address", gotAddr, addr);
      chk("R8 write strobe in data cycle", {31'd0, gotWr}, {31'd0, !ld});
      chk("R8 no later write", wrCnt, 0);
      if (!ld) chk((dIdx == 4'd15) ? "R3 pc store data" : "R3 store data", gotWd, sval);
    end
    if (expRdWe) begin
      chk("R9 load data", rdData, rdExp);
      chk("R9 rdIdx", {28'd0, rdIdx}, {28'd0, dIdx});
    end
    if (expWbWe) begin
      chk("R1 wbData", wbData, sum);
      chk("R1 wbIdx", {28'd0, wbIdx}, {28'd0, bIdx});
    end
    if (hold) begin
      @(negedge clk);
      chk("R10 held request ignored", {31'd0, doneValid}, 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL R10 watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    int dl[3] = '{2, 5, 15};
    int bl[2] = '{5, 15};
    rstN = 1'b0; reqValid = 1'b0; reqLoad = 1'b0; reqPre = 1'b0; reqUp = 1'b0;
    reqWb = 1'b0; reqOffIsReg = 1'b0; reqBaseIdx = '0; reqOffIdx = '0;
    reqDataIdx = '0; reqBase = '0; reqOffset = '0; reqStoreData = '0; reqPc = '0;
    memAbort = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 reset memCycle", {30'd0, memCycle}, 32'd3);
    chk("R11 reset busy", {31'd0, busy}, 32'd0);
    chk("R11 reset doneValid", {31'd0, doneValid}, 32'd0);
    chk("R11 reset memWrite", {31'd0, memWrite}, 32'd0);
    rstN = 1'b1;

    // main sweep: R1 R2 R3 R6 R7 R8 R9 R12
    for (int ld = 0; ld < 2; ld++)
      for (int pre = 0; pre < 2; pre++)
        for (int up = 0; up < 2; up++)
          for (int wb = 0; wb < 2; wb++)
            for (int lo = 0; lo < 4; lo++)
              for (int di = 0; di < 3; di++)
                for (int bi = 0; bi < 2; bi++)
                  doXfer(ld[0], pre[0], up[0], wb[0], 1'b1, 1'b0, 1'b0,
                         4'(bl[bi]), 4'd7, 4'(dl[di]),
                         32'h0001_2340 | 32'(lo), 32'h0000_0104,
                         32'hC0DE_F00D ^ 32'(lo), 32'h0000_8000 | 32'(lo));

    // refused combinations: R4
    for (int ld = 0; ld < 2; ld++)
      for (int pre = 0; pre < 2; pre++) begin
        doXfer(ld[0], pre[0], 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3, 4'd15, 4'd2,
               32'h100, 32'h4, 32'h1, 32'h8000);
        doXfer(ld[0], pre[0], 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd6, 4'd6, 4'd2,
               32'h200, 32'h8, 32'h2, 32'h8000);
      end

    // aborts: R5
    for (int ld = 0; ld < 2; ld++)
      for (int di = 0; di < 3; di++)
        doXfer(ld[0], 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'd5, 4'd0, 4'(dl[di]),
               32'h0000_3002, 32'h10, 32'hAAAA_5555, 32'h8000);

    // held requests during busy: R10
    doXfer(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4, 4'd0, 4'd15,
           32'h0000_4001, 32'h20, 32'h0, 32'h8000);
    doXfer(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd4, 4'd0, 4'd1,
           32'h0000_4003, 32'h20, 32'h1234_5678, 32'h8000);

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule